// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block produces the fetch address for a small 8-bit controller whose program memory holds 1024 words of 14-bit instructions. Each clock it chooses the next address. It can step by one, step by two to skip the next instruction, or hold while the core sleeps. It can also load a branch target, load a byte computed by the ALU, or return to an address saved on a two-entry hardware return stack. The decoder drives one strobe per control-flow kind. It also supplies the address field of the instruction word, the ALU result byte and the page-select bit of the status register.

Short branches and computed writes reach only part of the address space. Their top address bit comes from the page-select bit. Short calls and computed writes also force address bit 8 to zero. Long branches carry a full 10-bit target. Calls save the address that follows the current one. The return stack is a circular buffer with no overflow or underflow detection. An extra push replaces the oldest entry, and a pop always reads the most recent slot and then steps backwards.

Top module: `paged_pc_sequencer`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, fetch_addr is 3FFh. Both return-stack slots also reset to 3FFh.
- R2: A cycle with no strobe active advances fetch_addr by one, modulo 1024, so 3FFh is followed by 000h.
- R3: op_skip alone advances fetch_addr by two, modulo 1024, so 3FEh is followed by 000h.
- R4: op_sleep holds fetch_addr and leaves the return stack untouched, whatever other strobes are active.
- R5: op_jump loads {page_sel, addr_field[8:0]}. addr_field[9] is ignored.
- R6: op_call loads {page_sel, 1'b0, addr_field[7:0]} and pushes fetch_addr+1.
- R7: op_pcwr loads {page_sel, 1'b0, alu_byte}.
- R8: op_ljump and op_lcall load all ten bits of addr_field and ignore page_sel. op_lcall also pushes fetch_addr+1.
- R9: op_ret loads the most recently pushed address and removes it, so two nested calls return in reverse order.
- R10: After a third push without pops, the oldest entry is lost. Successive returns then give the newest, the second newest, and the newest again.
- R11: A pop beyond the stored entries wraps round the two slots. After reset it returns 3FFh.
- R12: When several strobes are active, one of them takes effect, chosen in this priority: sleep, ret, lcall, ljump, call, jump, pcwr, skip. Only the chosen operation changes the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_jump | input | 1 | Short jump within the selected page |
| op_call | input | 1 | Short call; pushes the return address |
| op_ljump | input | 1 | Long jump to a full 10-bit target |
| op_lcall | input | 1 | Long call; pushes the return address |
| op_ret | input | 1 | Return; pops the stack |
| op_pcwr | input | 1 | Computed write of the low address byte |
| op_skip | input | 1 | Skip the next instruction |
| op_sleep | input | 1 | Hold the address |
| addr_field | input | 10 | Target field of the instruction word |
| alu_byte | input | 8 | ALU result for computed writes |
| page_sel | input | 1 | Page-select bit from the status register |
| fetch_addr | output | 10 | Current fetch address |

## Verification
The bench uses the default parameters: a 10-bit address, an 8-bit data byte and a two-entry stack. With only 1024 addresses, both the step-by-one and the step-by-two cases can be driven across the 3FFh-to-000h wrap with a single long jump. With two slots, a third nested call and a return past the stored entries each take only a handful of cycles. This makes the circular overwrite and the wrap-round pop directly observable at fetch_addr.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    // Source chosen for the next fetch address
    typedef enum logic [3:0] {
        SRC_HOLD,
        SRC_INC,
        SRC_SKIP,
        SRC_PCWR,
        SRC_JUMP,
        SRC_CALL,
        SRC_LJUMP,
        SRC_LCALL,
        SRC_RET
    } pc_src_e;

    // Control strobes from the decoder, highest priority first
    typedef struct packed {
        logic sleep;
        logic ret;
        logic lcall;
        logic ljump;
        logic call;
        logic jump;
        logic pcwr;
        logic skip;
    } pc_ctl_t;

endpackage

// File: rtl/pcseq_arbiter.sv
module pcseq_arbiter
    import pcseq_pkg::*;
(
    input  pc_ctl_t ctl,
    output pc_src_e src,
    output logic    push,
    output logic    pop
);

    // Fixed priority (R12): sleep > ret > lcall > ljump > call > jump > pcwr > skip
    always_comb begin
        if (ctl.sleep)      src = SRC_HOLD;
        else if (ctl.ret)   src = SRC_RET;
        else if (ctl.lcall) src = SRC_LCALL;
        else if (ctl.ljump) src = SRC_LJUMP;
        else if (ctl.call)  src = SRC_CALL;
        else if (ctl.jump)  src = SRC_JUMP;
        else if (ctl.pcwr)  src = SRC_PCWR;
        else if (ctl.skip)  src = SRC_SKIP;
        else                src = SRC_INC;
    end

    always_comb begin
        push = (src == SRC_CALL) || (src == SRC_LCALL);
        pop  = (src == SRC_RET);
    end

endmodule

// File: rtl/pcseq_target.sv
module pcseq_target
    import pcseq_pkg::*;
#(
    parameter int PC_W   = 10,
    parameter int DATA_W = 8
) (
    input  pc_src_e           src,
    input  logic [PC_W-1:0]   pc_q,
    input  logic [PC_W-1:0]   addr_field,
    input  logic [DATA_W-1:0] alu_byte,
    input  logic              page_sel,
    input  logic [PC_W-1:0]   stack_top,
    output logic [PC_W-1:0]   next_pc,
    output logic [PC_W-1:0]   ret_addr
);

    localparam int JMP_W = PC_W - 1;   // short jump reaches a full page
    localparam int LOW_W = PC_W - 2;   // short call / computed write: half page

    logic [LOW_W-1:0] alu_low;
    logic [PC_W-1:0]  pc_inc1;
    logic [PC_W-1:0]  pc_inc2;

    // Fit the ALU byte to the low field: pad when narrower, trim when wider
    generate
        if (DATA_W < LOW_W) begin : g_pad
            assign alu_low = {{(LOW_W-DATA_W){1'b0}}, alu_byte};
        end else begin : g_trim
            assign alu_low = alu_byte[LOW_W-1:0];
        end
    endgenerate

    always_comb begin
        pc_inc1  = pc_q + PC_W'(1);
        pc_inc2  = pc_q + PC_W'(2);
        ret_addr = pc_inc1;
    end

    always_comb begin
        unique case (src)
            SRC_HOLD:  next_pc = pc_q;
            SRC_INC:   next_pc = pc_inc1;
            SRC_SKIP:  next_pc = pc_inc2;
            SRC_PCWR:  next_pc = {page_sel, 1'b0, alu_low};
            SRC_JUMP:  next_pc = {page_sel, addr_field[JMP_W-1:0]};
            SRC_CALL:  next_pc = {page_sel, 1'b0, addr_field[LOW_W-1:0]};
            SRC_LJUMP: next_pc = addr_field;
            SRC_LCALL: next_pc = addr_field;
            SRC_RET:   next_pc = stack_top;
            default:   next_pc = pc_inc1;
        endcase
    end

endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
    parameter int PC_W  = 10,
    parameter int DEPTH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    input  logic [PC_W-1:0] push_data,
    output logic [PC_W-1:0] top_data
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][PC_W-1:0] mem;
        logic [PTR_W-1:0]           ptr;   // slot holding the newest entry
    } stk_t;

    stk_t stk_d, stk_q;
    logic [PTR_W-1:0] ptr_fwd, ptr_back;

    always_comb begin
        ptr_fwd  = (stk_q.ptr == LAST) ? '0 : stk_q.ptr + PTR_W'(1);
        ptr_back = (stk_q.ptr == '0) ? LAST : stk_q.ptr - PTR_W'(1);
        top_data = stk_q.mem[stk_q.ptr];
    end

    // Circular buffer: a push overwrites the oldest slot, a pop steps back
    always_comb begin
        stk_d = stk_q;
        if (push) begin
            stk_d.ptr          = ptr_fwd;
            stk_d.mem[ptr_fwd] = push_data;
        end else if (pop) begin
            stk_d.ptr = ptr_back;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stk_q.mem <= '1;
            stk_q.ptr <= LAST;
        end else begin
            stk_q <= stk_d;
        end
    end

    // Pushed value becomes the top on the next cycle (R9)
    p_push_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> top_data == $past(push_data));

    // A pop moves to the other slot (R10)
    p_pop_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> stk_q.ptr != $past(stk_q.ptr));

    // Without push or pop the stored entries stay (R4)
    p_idle_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop) |=> $stable(stk_q));

endmodule

// File: rtl/paged_pc_sequencer.sv
module paged_pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int PC_W        = 10,
    parameter int DATA_W      = 8,
    parameter int STACK_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_jump,
    input  logic              op_call,
    input  logic              op_ljump,
    input  logic              op_lcall,
    input  logic              op_ret,
    input  logic              op_pcwr,
    input  logic              op_skip,
    input  logic              op_sleep,
    input  logic [PC_W-1:0]   addr_field,
    input  logic [DATA_W-1:0] alu_byte,
    input  logic              page_sel,
    output logic [PC_W-1:0]   fetch_addr
);

    localparam int LOW_W = PC_W - 2;

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } seq_t;

    seq_t            seq_d, seq_q;
    pc_ctl_t         ctl;
    pc_src_e         src;
    logic            push, pop;
    logic [PC_W-1:0] next_pc, ret_addr, stack_top;

    always_comb begin
        ctl = '{sleep: op_sleep, ret: op_ret, lcall: op_lcall, ljump: op_ljump,
                call: op_call, jump: op_jump, pcwr: op_pcwr, skip: op_skip};
    end

    pcseq_arbiter u_arb (
        .ctl  (ctl),
        .src  (src),
        .push (push),
        .pop  (pop)
    );

    pcseq_target #(
        .PC_W   (PC_W),
        .DATA_W (DATA_W)
    ) u_tgt (
        .src        (src),
        .pc_q       (seq_q.pc),
        .addr_field (addr_field),
        .alu_byte   (alu_byte),
        .page_sel   (page_sel),
        .stack_top  (stack_top),
        .next_pc    (next_pc),
        .ret_addr   (ret_addr)
    );

    pcseq_stack #(
        .PC_W  (PC_W),
        .DEPTH (STACK_DEPTH)
    ) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .push_data (ret_addr),
        .top_data  (stack_top)
    );

    always_comb begin
        seq_d    = seq_q;
        seq_d.pc = next_pc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q.pc <= '1;
        else        seq_q    <= seq_d;
    end

    assign fetch_addr = seq_q.pc;

    // ---------------- assertions ----------------
    logic [7:0] strb;
    assign strb = {op_sleep, op_ret, op_lcall, op_ljump, op_call, op_jump, op_pcwr, op_skip};

    p_reset_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> fetch_addr == '1);

    p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (strb == 8'h00) |=> fetch_addr == PC_W'($past(fetch_addr) + PC_W'(1)));

    p_step_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (strb == 8'h01) |=> fetch_addr == PC_W'($past(fetch_addr) + PC_W'(2)));

    p_sleep_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op_sleep |=> $stable(fetch_addr));

    p_short_jump_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (strb == 8'h04) |=> fetch_addr == {$past(page_sel), $past(addr_field[PC_W-2:0])});

    p_short_call_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (strb == 8'h08) |=> fetch_addr == {$past(page_sel), 1'b0, $past(addr_field[LOW_W-1:0])});

    p_pc_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (strb == 8'h02) |=> fetch_addr == {$past(page_sel), 1'b0, LOW_W'($past(alu_byte))});

    p_long_jump_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (strb == 8'h10 || strb == 8'h20) |=> fetch_addr == $past(addr_field));

endmodule

// File: tb/paged_pc_sequencer_bench.sv
module paged_pc_sequencer_bench;

    localparam logic [7:0] N  = 8'h00;
    localparam logic [7:0] SK = 8'h01;
    localparam logic [7:0] PW = 8'h02;
    localparam logic [7:0] JP = 8'h04;
    localparam logic [7:0] CL = 8'h08;
    localparam logic [7:0] LJ = 8'h10;
    localparam logic [7:0] LC = 8'h20;
    localparam logic [7:0] RT = 8'h40;
    localparam logic [7:0] SL = 8'h80;

    typedef struct packed {
        logic [7:0] strb;
        logic [9:0] addr;
        logic [7:0] alu;
        logic       page;
        logic [9:0] exp;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{N,          10'h000, 8'h00, 1'b0, 10'h000}, // R2 wrap from 3FF
        '{N,          10'h000, 8'h00, 1'b0, 10'h001}, // R2
        '{SK,         10'h000, 8'h00, 1'b0, 10'h003}, // R3
        '{JP,         10'h1A5, 8'h00, 1'b0, 10'h1A5}, // R5
        '{JP,         10'h0F0, 8'h00, 1'b1, 10'h2F0}, // R5 page 1
        '{JP,         10'h3FF, 8'h00, 1'b0, 10'h1FF}, // R5 bit 9 ignored
        '{CL,         10'h3C4, 8'h00, 1'b1, 10'h2C4}, // R6 push 200
        '{N,          10'h000, 8'h00, 1'b0, 10'h2C5}, // R2
        '{LC,         10'h155, 8'h00, 1'b1, 10'h155}, // R8 push 2C6
        '{RT,         10'h000, 8'h00, 1'b0, 10'h2C6}, // R9
        '{RT,         10'h000, 8'h00, 1'b0, 10'h200}, // R9
        '{PW,         10'h3FF, 8'h7E, 1'b1, 10'h27E}, // R7
        '{LJ,         10'h0AA, 8'h00, 1'b1, 10'h0AA}, // R8 page ignored
        '{SL|LJ,      10'h300, 8'h00, 1'b0, 10'h0AA}, // R4
        '{SL|RT,      10'h000, 8'h00, 1'b0, 10'h0AA}, // R4 no pop
        '{RT|SK|JP,   10'h000, 8'h00, 1'b0, 10'h2C6}, // R11 wrap pop
        '{RT,         10'h000, 8'h00, 1'b0, 10'h200}, // R11
        '{CL|JP|PW|SK,10'h044, 8'h11, 1'b0, 10'h044}, // R12 call wins, push 201
        '{LJ|CL,      10'h3A0, 8'h00, 1'b0, 10'h3A0}, // R12 ljump wins
        '{LC,         10'h010, 8'h00, 1'b0, 10'h010}, // R8 push 3A1
        '{CL,         10'h020, 8'h00, 1'b0, 10'h020}, // R10 push 011 over 201
        '{RT,         10'h000, 8'h00, 1'b0, 10'h011}, // R10
        '{RT,         10'h000, 8'h00, 1'b0, 10'h3A1}, // R10
        '{RT,         10'h000, 8'h00, 1'b0, 10'h011}, // R10 circular
        '{PW|SK,      10'h000, 8'hFF, 1'b0, 10'h0FF}, // R12 pcwr wins
        '{SK,         10'h000, 8'h00, 1'b0, 10'h101}, // R3
        '{RT|LC,      10'h123, 8'h00, 1'b0, 10'h3A1}, // R12 ret wins
        '{LJ,         10'h3FE, 8'h00, 1'b0, 10'h3FE}, // R8
        '{SK,         10'h000, 8'h00, 1'b0, 10'h000}, // R3 wrap
        '{N,          10'h000, 8'h00, 1'b0, 10'h001}  // R2
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] strb = '0;
    logic [9:0] addr_field = '0;
    logic [7:0] alu_byte = '0;
    logic       page_sel = 1'b0;
    logic [9:0] fetch_addr;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    paged_pc_sequencer u_paged_pc_sequencer (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_jump    (strb[2]),
        .op_call    (strb[3]),
        .op_ljump   (strb[4]),
        .op_lcall   (strb[5]),
        .op_ret     (strb[6]),
        .op_pcwr    (strb[1]),
        .op_skip    (strb[0]),
        .op_sleep   (strb[7]),
        .addr_field (addr_field),
        .alu_byte   (alu_byte),
        .page_sel   (page_sel),
        .fetch_addr (fetch_addr)
    );

    task automatic check(input logic [9:0] exp, input string tag);
        checks++;
        if (fetch_addr !== exp) begin
            fails++;
            $display("FAIL %s: fetch_addr=%h expected %h", tag, fetch_addr, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        strb       = v.strb;
        addr_field = v.addr;
        alu_byte   = v.alu;
        page_sel   = v.page;
        @(negedge clk);
    endtask

    task automatic do_reset();
        strb  = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        check(10'h3FF, "R1 after reset");
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            check(VECS[i].exp, $sformatf("vector %0d", i));
        end

        // Directed: reset mid-run, then pop on a fresh stack
        @(negedge clk);
        do_reset();
        check(10'h3FF, "R1 second reset");
        drive('{RT, 10'h000, 8'h00, 1'b0, 10'h3FF});
        check(10'h3FF, "R11 pop after reset");
        drive('{SL|SK, 10'h000, 8'h00, 1'b0, 10'h3FF});
        check(10'h3FF, "R4 sleep hold");
        drive('{N, 10'h000, 8'h00, 1'b0, 10'h000});
        check(10'h000, "R2 wrap after reset");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run incomplete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule